// File: doc/BRIEF.md
# Reset Sequencing Controller

This block merges every reset cause of a small microcontroller into one active-high system reset for the CPU and its peripherals. The causes are a power-on event, the bidirectional reset pin held low from outside, and three internal requests: watchdog timeout, low-voltage detect and illegal address. It also produces the enable for the open-drain pulldown that drives the reset pin low, so that devices on the board see internal resets.

After power-on, the block waits for the oscillator to report activity. It then counts a fixed stabilization interval before it releases the reset, and it extends that hold while the pin is still low. The pin level arrives from the Schmitt-trigger pad asynchronously and is synchronized inside. An internal request is stretched to a minimum pulldown length. The pulldown is never driven for power-on, nor when the pin is already low from outside. The block masks its own pulldown so that it does not detect itself as an external reset.

States: the power-on sequencer has `POR_WAIT_OSC`, `POR_COUNT`, `POR_PIN_HOLD` and `POR_DONE`. Its transitions are: oscillator seen (wait to count), count end with the pin high (count to done), count end with the pin low (count to pin hold), and pin high (pin hold to done). The external detector has `EXT_IDLE`, `EXT_ARMED` and `EXT_ACTIVE`. Its transitions are: first unmasked low sample (idle to armed), second consecutive low (armed to active), high sample (armed or active to idle). The request stretcher has `STR_IDLE`, `STR_MIN` and `STR_REQ`. Its transitions are: any request (idle to minimum, suppression latched), minimum done with the request still high (minimum to request), minimum done with the request low (minimum to idle), new rising request (minimum restart, or request to minimum), and request low (request to idle).

Top module: `rst_seq_ctrl`

## Requirements
- R1: From the power-on pulse until the oscillator-ready input is sampled high, `sys_rst` is 1 and `pin_pull_en` is 0.
- R2: With the pin high, once `osc_ready` is sampled high at clock edge e0, `sys_rst` stays 1 through edge e0+4063 and drops after edge e0+4064 (4064 cycles held; 12-bit counter).
- R3: If the synchronized pin is low when the stabilization count ends, `sys_rst` stays 1 until the pin returns high, and drops after the third edge following the pin's rise.
- R4: The pin passes through a two-flop synchronizer. Two consecutive low synchronized samples start an external reset, which is visible after the fourth edge following the pin's fall. The reset lasts while the pin is low and releases after the third edge following its rise. A pin low for one cycle produces no reset; a pin low for L ≥ 2 cycles gives a reset L-1 cycles wide.
- R5: Any of the three request inputs sampled high at an edge makes `sys_rst` 1 after that edge.
- R6: `pin_pull_en` is never 1 while the power-on hold is active, and a request accepted during that hold never drives it.
- R7: A request arriving while the pin is not low from outside drives `pin_pull_en` and `sys_rst` from the edge that samples it, for max(4, request length) cycles.
- R8: A request arriving while an external reset is being detected leaves `pin_pull_en` at 0, but `sys_rst` stays 1.
- R9: A rising edge on any request at step r of an active stretch restarts the 4-cycle minimum, so that the stretch lasts max(request length, r+4) cycles.
- R10: The block's own pulldown low on the pin, including the synchronizer lag after release, is never taken as an external reset: for a request, the `sys_rst` width equals the `pin_pull_en` width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal processor clock |
| por_pulse | input | 1 | Power-on event, active high, asynchronous |
| osc_ready | input | 1 | Oscillator active flag |
| pin_level | input | 1 | Reset pin level after the Schmitt trigger, asynchronous |
| wdog_req | input | 1 | Watchdog timeout request |
| lowv_req | input | 1 | Low-voltage detect request |
| bad_addr_req | input | 1 | Illegal-address request |
| sys_rst | output | 1 | Internal reset for CPU and peripherals, active high |
| pin_pull_en | output | 1 | Open-drain pulldown enable for the reset pin |

## Verification
The bench drives inputs on the falling edge and counts samples from the stimulus step. A request shows on both outputs at the next sample. An external pin low shows on `sys_rst` four samples after it is driven, and a pin release clears the reset three samples after the rise. The power-on release appears at sample 4065 after `osc_ready` is raised. Each check records the first sample index and the number of active samples over a window that covers the whole response. These are compared with the widths above, computed by bench functions for random request lengths, restart points and pin pulses.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [1:0] {
        POR_WAIT_OSC,
        POR_COUNT,
        POR_PIN_HOLD,
        POR_DONE
    } por_state_e;

    typedef enum logic [1:0] {
        EXT_IDLE,
        EXT_ARMED,
        EXT_ACTIVE
    } ext_state_e;

    typedef enum logic [1:0] {
        STR_IDLE,
        STR_MIN,
        STR_REQ
    } str_state_e;

    // Counter width able to hold values 0 .. n-1, never below one bit.
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_evt,
    input  logic pin_raw,
    output logic pin_sync
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or posedge por_evt) begin
                if (por_evt) chain <= 1'b1;
                else         chain <= pin_raw;
            end
        end else begin : g_multi
            always_ff @(posedge clk or posedge por_evt) begin
                if (por_evt) chain <= '1;
                else         chain <= {chain[STAGES-2:0], pin_raw};
            end
        end
    endgenerate

    assign pin_sync = chain[STAGES-1];

endmodule

// File: rtl/rst_por_timer.sv
module rst_por_timer
    import rst_seq_pkg::*;
#(
    parameter int STAB_CYCLES = 4064,
    parameter int CNT_W       = 12
) (
    input  logic clk,
    input  logic por_evt,
    input  logic osc_ready,
    input  logic pin_sync,
    output logic por_hold
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYCLES - 1);

    por_state_e       state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    always_ff @(posedge clk or posedge por_evt) begin
        if (por_evt) begin
            state <= POR_WAIT_OSC;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            POR_WAIT_OSC: begin
                if (osc_ready) begin
                    state_n = POR_COUNT;
                    cnt_n   = '0;
                end
            end
            POR_COUNT: begin
                if (cnt == LAST) begin
                    state_n = pin_sync ? POR_DONE : POR_PIN_HOLD;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            POR_PIN_HOLD: begin
                if (pin_sync) state_n = POR_DONE;
            end
            POR_DONE: begin
                state_n = POR_DONE;
            end
            default: state_n = POR_WAIT_OSC;
        endcase
    end

    always_comb begin
        por_hold = (state != POR_DONE);
    end

    // R2
    por_cnt_range_chk: assert property (@(posedge clk) disable iff (por_evt)
        cnt <= LAST);

    // R3
    por_release_pin_high_chk: assert property (@(posedge clk) disable iff (por_evt)
        $fell(por_hold) |-> $past(pin_sync));

    // R1
    por_wait_hold_chk: assert property (@(posedge clk) disable iff (por_evt)
        (state == POR_WAIT_OSC && !osc_ready) |=> por_hold);

endmodule

// File: rtl/rst_ext_detect.sv
module rst_ext_detect
    import rst_seq_pkg::*;
#(
    parameter int MASK_DEPTH = 2
) (
    input  logic clk,
    input  logic por_evt,
    input  logic pin_sync,
    input  logic pull_en,
    output logic ext_active,
    output logic ext_busy
);

    ext_state_e            state, state_n;
    logic [MASK_DEPTH-1:0] pull_dly;
    logic                  self_low;

    // Delayed copies of the pulldown enable cover the synchronizer lag.
    generate
        if (MASK_DEPTH == 1) begin : g_dly1
            always_ff @(posedge clk or posedge por_evt) begin
                if (por_evt) pull_dly <= '0;
                else         pull_dly <= pull_en;
            end
        end else begin : g_dlyn
            always_ff @(posedge clk or posedge por_evt) begin
                if (por_evt) pull_dly <= '0;
                else         pull_dly <= {pull_dly[MASK_DEPTH-2:0], pull_en};
            end
        end
    endgenerate

    assign self_low = pull_en | (|pull_dly);

    always_ff @(posedge clk or posedge por_evt) begin
        if (por_evt) state <= EXT_IDLE;
        else         state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            EXT_IDLE: begin
                if (!pin_sync && !self_low) state_n = EXT_ARMED;
            end
            EXT_ARMED: begin
                if (pin_sync)       state_n = EXT_IDLE;
                else if (!self_low) state_n = EXT_ACTIVE;
            end
            EXT_ACTIVE: begin
                if (pin_sync) state_n = EXT_IDLE;
            end
            default: state_n = EXT_IDLE;
        endcase
    end

    always_comb begin
        ext_active = (state == EXT_ACTIVE);
        ext_busy   = (state != EXT_IDLE);
    end

    // R4
    ext_two_low_chk: assert property (@(posedge clk) disable iff (por_evt)
        $rose(ext_active) |-> (!$past(pin_sync) && !$past(pin_sync, 2)));

    // R4
    ext_release_high_chk: assert property (@(posedge clk) disable iff (por_evt)
        $fell(ext_active) |-> $past(pin_sync));

    // R10
    ext_self_mask_chk: assert property (@(posedge clk) disable iff (por_evt)
        (state == EXT_IDLE && pull_en) |=> (state == EXT_IDLE));

endmodule

// File: rtl/rst_src_stretch.sv
module rst_src_stretch
    import rst_seq_pkg::*;
#(
    parameter int N_SRC    = 3,
    parameter int MIN_PULL = 4,
    parameter int CNT_W    = 2
) (
    input  logic             clk,
    input  logic             por_evt,
    input  logic [N_SRC-1:0] req,
    input  logic             por_hold,
    input  logic             ext_busy,
    output logic             str_active,
    output logic             pull_en
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_PULL - 1);

    str_state_e       state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             supp, supp_n;
    logic [N_SRC-1:0] req_q;
    logic             req_any;
    logic             req_rise;

    assign req_any  = |req;
    assign req_rise = |(req & ~req_q);

    always_ff @(posedge clk or posedge por_evt) begin
        if (por_evt) begin
            state <= STR_IDLE;
            cnt   <= '0;
            supp  <= 1'b0;
            req_q <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            supp  <= supp_n;
            req_q <= req;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        supp_n  = supp;
        unique case (state)
            STR_IDLE: begin
                if (req_any) begin
                    state_n = STR_MIN;
                    cnt_n   = '0;
                    supp_n  = por_hold | ext_busy;
                end
            end
            STR_MIN: begin
                if (req_rise) begin
                    cnt_n = '0;
                end else if (cnt == LAST) begin
                    state_n = req_any ? STR_REQ : STR_IDLE;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            STR_REQ: begin
                if (req_rise) begin
                    state_n = STR_MIN;
                    cnt_n   = '0;
                end else if (!req_any) begin
                    state_n = STR_IDLE;
                end
            end
            default: state_n = STR_IDLE;
        endcase
    end

    always_comb begin
        str_active = (state != STR_IDLE);
        pull_en    = (state != STR_IDLE) && !supp;
    end

    // R7
    str_min_len_chk: assert property (@(posedge clk) disable iff (por_evt)
        (state == STR_MIN && cnt != LAST) |=> (state != STR_IDLE));

    // R8
    str_ext_supp_chk: assert property (@(posedge clk) disable iff (por_evt)
        (state == STR_IDLE && req_any && ext_busy) |=> !pull_en);

    // R9
    str_restart_chk: assert property (@(posedge clk) disable iff (por_evt)
        (str_active && req_rise) |=> (state == STR_MIN && cnt == '0));

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int STAB_CYCLES = 4064,
    parameter int MIN_PULL    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_pulse,
    input  logic osc_ready,
    input  logic pin_level,
    input  logic wdog_req,
    input  logic lowv_req,
    input  logic bad_addr_req,
    output logic sys_rst,
    output logic pin_pull_en
);

    localparam int N_SRC     = 3;
    localparam int POR_CNT_W = cnt_w(STAB_CYCLES);
    localparam int STR_CNT_W = cnt_w(MIN_PULL);

    logic             pin_sync;
    logic             por_hold;
    logic             ext_active;
    logic             ext_busy;
    logic             str_active;
    logic             pull_en;
    logic [N_SRC-1:0] req_vec;

    assign req_vec = {bad_addr_req, lowv_req, wdog_req};

    rst_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .por_evt  (por_pulse),
        .pin_raw  (pin_level),
        .pin_sync (pin_sync)
    );

    rst_por_timer #(
        .STAB_CYCLES (STAB_CYCLES),
        .CNT_W       (POR_CNT_W)
    ) u_por (
        .clk       (clk),
        .por_evt   (por_pulse),
        .osc_ready (osc_ready),
        .pin_sync  (pin_sync),
        .por_hold  (por_hold)
    );

    rst_ext_detect #(
        .MASK_DEPTH (SYNC_STAGES)
    ) u_ext (
        .clk        (clk),
        .por_evt    (por_pulse),
        .pin_sync   (pin_sync),
        .pull_en    (pull_en),
        .ext_active (ext_active),
        .ext_busy   (ext_busy)
    );

    rst_src_stretch #(
        .N_SRC    (N_SRC),
        .MIN_PULL (MIN_PULL),
        .CNT_W    (STR_CNT_W)
    ) u_str (
        .clk        (clk),
        .por_evt    (por_pulse),
        .req        (req_vec),
        .por_hold   (por_hold),
        .ext_busy   (ext_busy),
        .str_active (str_active),
        .pull_en    (pull_en)
    );

    assign sys_rst     = por_hold | ext_active | str_active;
    assign pin_pull_en = pull_en;

    // R6
    pull_no_por_chk: assert property (@(posedge clk) disable iff (por_pulse)
        por_hold |-> !pin_pull_en);

    // R5
    req_in_rst_chk: assert property (@(posedge clk) disable iff (por_pulse)
        (|req_vec) |=> sys_rst);

endmodule

// File: tb/rst_seq_ctrl_bench.sv
module rst_seq_ctrl_bench;

    logic clk = 1'b0;
    logic por_pulse;
    logic osc_ready;
    logic ext_low;
    logic wdog_req, lowv_req, bad_addr_req;
    logic sys_rst, pin_pull_en;
    logic pin_level;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    // Open-drain pin: low when driven from outside or by the block.
    assign pin_level = ~(ext_low | pin_pull_en);

    rst_seq_ctrl u_rst_seq_ctrl (
        .clk          (clk),
        .por_pulse    (por_pulse),
        .osc_ready    (osc_ready),
        .pin_level    (pin_level),
        .wdog_req     (wdog_req),
        .lowv_req     (lowv_req),
        .bad_addr_req (bad_addr_req),
        .sys_rst      (sys_rst),
        .pin_pull_en  (pin_pull_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int exp_req_width(input int len, input int rs);
        return (rs > 0) ? max2(len, rs + 4) : max2(len, 4);
    endfunction

    function automatic int exp_ext_width(input int len);
        return (len >= 2) ? len - 1 : 0;
    endfunction

    function automatic int exp_ext_first(input int len);
        return (len >= 2) ? 4 : -1;
    endfunction

    task automatic set_req(input int idx, input logic v);
        case (idx)
            0: wdog_req = v;
            1: lowv_req = v;
            default: bad_addr_req = v;
        endcase
    endtask

    // kind 0..2 = request source, 3 = external pin low. rs > 0 adds a
    // one-cycle pulse on the next source at that step.
    task automatic run_pulse(input int kind, input int len, input int rs,
                             output int f_pull, output int w_pull,
                             output int f_rst, output int w_rst);
        int window;
        window = len + rs + 14;
        f_pull = -1; w_pull = 0; f_rst = -1; w_rst = 0;
        for (int i = 0; i <= window; i++) begin
            @(negedge clk);
            if (pin_pull_en) begin
                if (f_pull < 0) f_pull = i;
                w_pull++;
            end
            if (sys_rst) begin
                if (f_rst < 0) f_rst = i;
                w_rst++;
            end
            if (kind == 3) ext_low = (i < len);
            else begin
                set_req(kind, i < len);
                if (rs > 0) set_req((kind + 1) % 3, (i == rs) || ((i < len) && (((kind + 1) % 3) == kind)));
            end
        end
    endtask

    task automatic check_req(input int kind, input int len, input int rs);
        int fp, wp, fr, wr, ew;
        run_pulse(kind, len, rs, fp, wp, fr, wr);
        ew = exp_req_width(len, rs);
        chk(fp == 1, "R7 pulldown start", fp, 1);
        chk(fr == 1, "R5 reset start on request", fr, 1);
        chk(wp == ew, (rs > 0) ? "R9 restarted pulldown width" : "R7 pulldown width", wp, ew);
        chk(wr == wp, "R10 reset width equals pulldown width", wr, wp);
    endtask

    task automatic check_ext(input int len);
        int fp, wp, fr, wr;
        run_pulse(3, len, 0, fp, wp, fr, wr);
        chk(fr == exp_ext_first(len), "R4 external reset start", fr, exp_ext_first(len));
        chk(wr == exp_ext_width(len), "R4 external reset width", wr, exp_ext_width(len));
        chk(wp == 0, "R8 no pulldown for external reset", wp, 0);
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int pull_seen;
        int rst_low_seen;
        void'($urandom(32'd1998));
        por_pulse = 1'b1;
        osc_ready = 1'b0;
        ext_low = 1'b0;
        wdog_req = 1'b0; lowv_req = 1'b0; bad_addr_req = 1'b0;

        // R1: reset state during the power-on pulse.
        gap(3);
        chk(sys_rst == 1'b1, "R1 reset during power-on pulse", sys_rst, 1);
        chk(pin_pull_en == 1'b0, "R1 no pulldown during power-on pulse", pin_pull_en, 0);
        por_pulse = 1'b0;

        // R1 and R6: waiting for the oscillator, with a watchdog request.
        pull_seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pin_pull_en) pull_seen++;
            if (!sys_rst) rst_low_seen = 1;
            wdog_req = (i == 3);
        end
        chk(sys_rst == 1'b1, "R1 reset held before oscillator ready", sys_rst, 1);
        chk(pull_seen == 0, "R6 no pulldown for request during power-on", pull_seen, 0);

        // R2: stabilization count after oscillator ready.
        pull_seen = 0;
        for (int i = 0; i <= 4066; i++) begin
            @(negedge clk);
            if (pin_pull_en) pull_seen++;
            if (i == 4064) chk(sys_rst == 1'b1, "R2 reset at last count sample", sys_rst, 1);
            if (i == 4065) chk(sys_rst == 1'b0, "R2 reset released after 4064 cycles", sys_rst, 0);
            if (i == 0) osc_ready = 1'b1;
        end
        chk(pull_seen == 0, "R6 no pulldown during power-on count", pull_seen, 0);

        // Directed cases.
        check_ext(1);
        gap(6);
        check_ext(2);
        gap(6);
        check_req(0, 1, 0);
        gap(6);
        check_req(1, 4, 0);
        gap(6);
        check_req(2, 7, 0);
        gap(6);
        check_req(0, 1, 2);
        gap(6);
        check_req(1, 6, 5);
        gap(6);

        // R8: request while the pin is held low from outside.
        ext_low = 1'b1;
        gap(6);
        pull_seen = 0;
        rst_low_seen = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (pin_pull_en) pull_seen++;
            if (!sys_rst) rst_low_seen++;
            lowv_req = (i == 1);
        end
        chk(pull_seen == 0, "R8 pulldown off during external reset", pull_seen, 0);
        chk(rst_low_seen == 0, "R8 reset held during external reset", rst_low_seen, 0);
        ext_low = 1'b0;
        gap(4);
        chk(sys_rst == 1'b0, "R8 reset released after pin rise", sys_rst, 0);
        gap(6);

        // Random mix of requests, restarts and pin pulses.
        for (int n = 0; n < 40; n++) begin
            int kind, len, rs;
            kind = int'($urandom % 4);
            len  = 1 + int'($urandom % 9);
            rs   = 0;
            if (kind < 3 && ($urandom % 2) == 1)
                rs = 1 + int'($urandom % (max2(len, 4) - 1));
            if (kind == 3) check_ext(len);
            else           check_req(kind, len, rs);
            gap(8);
        end

        // R3: second power-on with the pin held low past the count.
        ext_low = 1'b1;
        @(negedge clk);
        por_pulse = 1'b1;
        gap(2);
        por_pulse = 1'b0;
        pull_seen = 0;
        for (int i = 0; i <= 4080; i++) begin
            @(negedge clk);
            if (pin_pull_en) pull_seen++;
            if (i == 4075) chk(sys_rst == 1'b1, "R3 reset held while pin low after count", sys_rst, 1);
            if (i == 4077) chk(sys_rst == 1'b1, "R3 reset held two samples after pin rise", sys_rst, 1);
            if (i == 4078) chk(sys_rst == 1'b0, "R3 reset released third sample after pin rise", sys_rst, 0);
            if (i == 4075) ext_low = 1'b0;
        end
        chk(pull_seen == 0, "R6 no pulldown in second power-on", pull_seen, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule